// File: doc/BRIEF.md
# I2C Register Target with Strapped Address

This block is an I2C target that gives a bus controller byte access to a 64-entry register file. Its 7-bit bus address comes from a strap pin. The pin is sampled while reset is held, and sampled again when software issues a soft-reset or reload command through the register file. A controller sets a register pointer with the first data byte of a write. Later bytes are written or read at that pointer, and the pointer advances by one after every byte.

A group of sample registers holds data that arrives from a sampling engine on `smp_we`/`smp_data`. The bus cannot write these registers. A new sample is first parked in a hold buffer. It is copied into the sample registers only when the bus is idle and at least one STOP has been seen since the previous copy. As a result, a controller reading several sample bytes in one transfer always sees bytes from the same sample.

SCL and SDA are oversampled by the system clock. SDA is driven only as an open-drain pull-down enable, `sda_oe`.

Top module: `i2c_regslave`

## Requirements
- R1: The bus address is 0x4C when `strap` is low during reset, and 0x6C when it is high. After reset, changes on `strap` have no effect until a re-sample command (R2).
- R2: Writing register 0x24 re-samples `strap` when bit 7 or bit 6 of the written byte is set. Bit 6 also clears every register to 0x00. Register 0x24 stores nothing and always reads 0x00.
- R3: A write transfer is START, the address with R/W=0, a pointer byte, then data bytes. The target pulls SDA low in the 9th clock of every byte. A data byte reaches its register only after its acknowledge clock has ended.
- R4: A read transfer sets the pointer with a write, then sends a repeated START and the address with R/W=1. The target shifts out register bytes MSB first, and the transfer ends at the controller's NAK and STOP.
- R5: Successive data bytes of one transfer, read or write, go to successive register addresses. The pointer wraps from 0x3F to 0x00.
- R6: When the address does not match, the target does not acknowledge, and it ignores the rest of the transfer up to the next START or STOP.
- R7: Sample registers 0x02 to 0x07 (bytes of `smp_data`, LSB byte at 0x02) are read-only from the bus. Bus writes to them have no effect.
- R8: Sample data reaches registers 0x02 to 0x07 only while the bus is idle and after a STOP has been seen since the previous update. Until then the sample is held, and a newer sample replaces a held one.
- R9: `sda_oe` changes only while SCL is low.
- R10: A START in the middle of a byte abandons that byte and restarts address reception. The register pointer is kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low reset; `strap` is sampled while it is low |
| strap | input | 1 | Address strap pin |
| scl_in | input | 1 | Bus clock line, asynchronous |
| sda_in | input | 1 | Bus data line, asynchronous |
| smp_we | input | 1 | One-cycle strobe that offers a new sample |
| smp_data | input | 48 | Sample bytes; bits 7:0 go to register 0x02 |
| sda_oe | output | 1 | Pull SDA low when high |
| reg_q | output | 512 | Register file contents, register n at bits 8n+7:8n |

## Verification
SCL and SDA each pass two synchroniser flops and an edge-detect flop. An SCL falling edge therefore moves `sda_oe` about three system cycles later. The bench holds every bus phase for 31 cycles and samples SDA in the middle of the SCL high time, so the target's reply has settled long before it is read.

A register write lands about four cycles after the falling edge that ends its acknowledge clock. A held sample is committed two cycles after `smp_we`, or two cycles after the STOP that releases it. The bench checks `reg_q` only after several idle cycles have passed following a STOP or a sample strobe.

A coherent-read scenario sends a new sample in the middle of a read. It then checks both the bytes read back during that transfer and the register contents after the STOP.

// File: rtl/i2c_regslave.sv
module i2c_regslave #(
  parameter int          AW       = 6,
  parameter logic [6:0]  ADDR_LO  = 7'h4C,
  parameter logic [6:0]  ADDR_HI  = 7'h6C,
  parameter int          SMP_BASE = 2,
  parameter int          SMP_N    = 6,
  parameter logic [5:0]  CMD_ADDR = 6'h24,
  parameter int          CLR_BIT  = 6,
  parameter int          RLD_BIT  = 7
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       strap,
  input  logic                       scl_in,
  input  logic                       sda_in,
  input  logic                       smp_we,
  input  logic [SMP_N*8-1:0]         smp_data,
  output logic                       sda_oe,
  output logic [(1<<AW)*8-1:0]       reg_q
);
  localparam int NREG = 1 << AW;

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_WRB, S_ACK, S_RDB, S_MACK, S_SKIP} st_t;

  logic [2:0] scl_r, sda_r;
  logic       scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_r <= 3'b111;
      sda_r <= 3'b111;
    end else begin
      scl_r <= {scl_r[1:0], scl_in};
      sda_r <= {sda_r[1:0], sda_in};
    end

  assign scl_s     = scl_r[1];
  assign sda_s     = sda_r[1];
  assign scl_rise  = scl_s & ~scl_r[2];
  assign scl_fall  = ~scl_s & scl_r[2];
  assign start_det = scl_s & scl_r[2] & ~sda_s & sda_r[2];
  assign stop_det  = scl_s & scl_r[2] & sda_s & ~sda_r[2];

  st_t          st;
  logic [3:0]   bitcnt;
  logic [7:0]   shreg;
  logic [AW-1:0] ptr;
  logic         have_ptr, rw, from_addr, mack, busy, stop_since, addr_sel, pend;
  logic [SMP_N*8-1:0] pend_data;
  logic [7:0]   mem [NREG];
  logic [6:0]   dev_addr;
  logic         wr_stb, is_smp, cmd_hit, clr, resample, commit;

  assign dev_addr = addr_sel ? ADDR_HI : ADDR_LO;
  assign wr_stb   = (st == S_ACK) && scl_fall && !from_addr && have_ptr && !start_det && !stop_det;
  assign is_smp   = (int'(ptr) >= SMP_BASE) && (int'(ptr) < SMP_BASE + SMP_N);
  assign cmd_hit  = wr_stb && (ptr == CMD_ADDR);
  assign clr      = cmd_hit && shreg[CLR_BIT];
  assign resample = cmd_hit && (shreg[CLR_BIT] || shreg[RLD_BIT]);
  assign commit   = pend && !busy && stop_since;
  assign sda_oe   = (st == S_ACK) || ((st == S_RDB) && !shreg[7]);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st        <= S_IDLE;
      bitcnt    <= '0;
      shreg     <= '0;
      ptr       <= '0;
      have_ptr  <= 1'b0;
      rw        <= 1'b0;
      from_addr <= 1'b0;
      mack      <= 1'b0;
      busy      <= 1'b0;
    end else if (start_det) begin
      st     <= S_ADDR;
      bitcnt <= '0;
      busy   <= 1'b1;
    end else if (stop_det) begin
      st   <= S_IDLE;
      busy <= 1'b0;
    end else begin
      case (st)
        S_ADDR, S_WRB: begin
          if (scl_rise) begin
            shreg  <= {shreg[6:0], sda_s};
            bitcnt <= bitcnt + 4'd1;
          end else if (scl_fall && bitcnt == 4'd8) begin
            bitcnt <= '0;
            if (st == S_WRB) begin
              st        <= S_ACK;
              from_addr <= 1'b0;
            end else if (shreg[7:1] == dev_addr) begin
              st        <= S_ACK;
              from_addr <= 1'b1;
              rw        <= shreg[0];
              if (!shreg[0]) have_ptr <= 1'b0;
            end else begin
              st <= S_SKIP;
            end
          end
        end
        S_ACK: if (scl_fall) begin
          if (from_addr && rw) begin
            st    <= S_RDB;
            shreg <= mem[ptr];
          end else begin
            st <= S_WRB;
          end
          if (!from_addr) begin
            if (!have_ptr) begin
              ptr      <= shreg[AW-1:0];
              have_ptr <= 1'b1;
            end else begin
              ptr <= ptr + 1'b1;
            end
          end
        end
        S_RDB: if (scl_fall) begin
          if (bitcnt == 4'd7) begin
            st     <= S_MACK;
            bitcnt <= '0;
            ptr    <= ptr + 1'b1;
          end else begin
            shreg  <= {shreg[6:0], 1'b0};
            bitcnt <= bitcnt + 4'd1;
          end
        end
        S_MACK: begin
          if (scl_rise) mack <= !sda_s;
          else if (scl_fall) begin
            if (mack) begin
              st    <= S_RDB;
              shreg <= mem[ptr];
            end else begin
              st <= S_SKIP;
            end
          end
        end
        default: ;
      endcase
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) addr_sel <= strap;
    else if (resample) addr_sel <= strap;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pend       <= 1'b0;
      pend_data  <= '0;
      stop_since <= 1'b1;
    end else begin
      if (smp_we) begin
        pend      <= 1'b1;
        pend_data <= smp_data;
      end else if (commit) begin
        pend <= 1'b0;
      end
      if (stop_det) stop_since <= 1'b1;
      else if (commit) stop_since <= 1'b0;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) mem[i] <= '0;
    end else begin
      if (clr) begin
        for (int i = 0; i < NREG; i++) mem[i] <= '0;
      end else if (wr_stb && !is_smp && !cmd_hit) begin
        mem[ptr] <= shreg;
      end
      if (commit) begin
        for (int i = 0; i < SMP_N; i++) mem[AW'(SMP_BASE + i)] <= pend_data[i*8 +: 8];
      end
    end

  for (genvar g = 0; g < NREG; g++) begin : g_out
    assign reg_q[g*8 +: 8] = mem[g];
  end

  assert_oe_scl_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> (!scl_s || $past(start_det || stop_det)));

  assert_write_after_ack_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> $past(sda_oe));

  assert_ptr_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && ptr == '1) |=> (ptr == '0));

  assert_commit_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(reg_q[SMP_BASE*8 +: SMP_N*8]) |-> (!$past(busy) || $past(clr)));

  assert_addr_resample_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(addr_sel) |-> $past(resample));

endmodule

// File: tb/test_i2c_regslave.sv
module test_i2c_regslave;
  localparam int Q = 31;

  logic clk = 1'b0, rst_n = 1'b0, strap = 1'b0;
  logic scl = 1'b1, m_low = 1'b0, smp_we = 1'b0;
  logic [47:0] smp_data = '0;
  logic sda_oe;
  logic [511:0] reg_q;
  wire  sda_line = !(m_low || sda_oe);

  int nchk = 0, nfail = 0, r9_bad = 0, scl_hi = 0;
  logic oe_prev = 1'b0;

  always #4 clk = ~clk;

  i2c_regslave i_i2c_regslave (
    .clk(clk), .rst_n(rst_n), .strap(strap), .scl_in(scl), .sda_in(sda_line),
    .smp_we(smp_we), .smp_data(smp_data), .sda_oe(sda_oe), .reg_q(reg_q));

  always @(negedge clk) begin
    if (rst_n && sda_oe !== oe_prev && scl_hi >= 3) r9_bad <= r9_bad + 1;
    oe_prev <= sda_oe;
    scl_hi  <= scl ? scl_hi + 1 : 0;
  end

  task automatic tk(input int n); repeat (n) @(negedge clk); endtask

  task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  function automatic logic [7:0] rg(input int a); return reg_q[a*8 +: 8]; endfunction

  task automatic i2c_start; m_low = 0; tk(Q); scl = 1; tk(Q); m_low = 1; tk(Q); scl = 0; tk(Q); endtask
  task automatic i2c_stop;  m_low = 1; tk(Q); scl = 1; tk(Q); m_low = 0; tk(2*Q); endtask
  task automatic wbit(input logic b); m_low = !b; tk(Q); scl = 1; tk(2*Q); scl = 0; tk(Q); endtask
  task automatic rbit(output logic b); m_low = 0; tk(Q); scl = 1; tk(Q); b = sda_line; tk(Q); scl = 0; tk(Q); endtask

  task automatic wbyte(input logic [7:0] d, output logic ack);
    logic x;
    for (int i = 7; i >= 0; i--) wbit(d[i]);
    rbit(x);
    ack = !x;
  endtask

  task automatic rbyte(output logic [7:0] d, input logic ack);
    for (int i = 7; i >= 0; i--) rbit(d[i]);
    wbit(!ack);
  endtask

  task automatic pulse_smp(input logic [47:0] d);
    smp_data = d; smp_we = 1; tk(1); smp_we = 0;
  endtask

  task automatic t_reset;
    chk("R1 registers zero after reset", {63'd0, |reg_q}, 64'd0);
    chk("R9 sda released after reset", {63'd0, sda_oe}, 64'd0);
  endtask

  task automatic t_write_read;
    logic a; logic [7:0] d;
    i2c_start; wbyte(8'h98, a); chk("R3 address ack", a, 1);
    wbyte(8'h10, a); chk("R3 pointer ack", a, 1);
    wbyte(8'hA5, a); chk("R3 data ack", a, 1);
    wbyte(8'h3C, a); i2c_stop; tk(8);
    chk("R3 reg 0x10 written", rg(16), 8'hA5);
    chk("R5 reg 0x11 written", rg(17), 8'h3C);
    i2c_start; wbyte(8'h98, a); wbyte(8'h10, a);
    i2c_start; wbyte(8'h99, a); chk("R4 read address ack", a, 1);
    rbyte(d, 1); chk("R4 first read byte", d, 8'hA5);
    rbyte(d, 0); chk("R5 second read byte", d, 8'h3C);
    i2c_stop; tk(8);
  endtask

  task automatic t_wrap;
    logic a;
    i2c_start; wbyte(8'h98, a); wbyte(8'h3F, a); wbyte(8'h11, a); wbyte(8'h22, a); i2c_stop; tk(8);
    chk("R5 reg 0x3F", rg(63), 8'h11);
    chk("R5 wrapped to reg 0x00", rg(0), 8'h22);
  endtask

  task automatic t_bad_addr;
    logic a;
    i2c_start; wbyte(8'hD8, a); chk("R6 no ack for other address", a, 0);
    wbyte(8'h10, a); wbyte(8'h77, a); chk("R6 data not acked", a, 0);
    i2c_stop; tk(8);
    chk("R6 reg 0x10 untouched", rg(16), 8'hA5);
  endtask

  task automatic t_rs_abort;
    logic a; logic [7:0] d;
    i2c_start; wbyte(8'h98, a); wbyte(8'h10, a);
    wbit(1); wbit(0); wbit(1);
    i2c_start; wbyte(8'h99, a); chk("R10 address after aborted byte", a, 1);
    rbyte(d, 0); chk("R10 pointer kept", d, 8'hA5);
    i2c_stop; tk(8);
    chk("R10 partial byte not written", rg(16), 8'hA5);
  endtask

  task automatic t_sample;
    logic a; logic [7:0] d;
    pulse_smp(48'h060504030201); tk(8);
    chk("R8 idle sample committed", reg_q[16 +: 48], 48'h060504030201);
    pulse_smp(48'h161514131211); tk(8);
    chk("R8 held without STOP", reg_q[16 +: 48], 48'h060504030201);
    i2c_start; wbyte(8'h98, a); wbyte(8'h02, a);
    i2c_start; wbyte(8'h99, a);
    rbyte(d, 1); chk("R8 coherent byte 0", d, 8'h01);
    pulse_smp(48'h262524232221);
    rbyte(d, 0); chk("R8 coherent byte 1", d, 8'h02);
    i2c_stop; tk(8);
    chk("R8 newest sample after STOP", reg_q[16 +: 48], 48'h262524232221);
  endtask

  task automatic t_sample_ro;
    logic a;
    i2c_start; wbyte(8'h98, a); wbyte(8'h02, a); wbyte(8'hFF, a); i2c_stop; tk(8);
    chk("R7 sample reg not writable", rg(2), 8'h21);
  endtask

  task automatic t_strap;
    logic a; logic [7:0] d;
    strap = 1;
    i2c_start; wbyte(8'h98, a); wbyte(8'h24, a); wbyte(8'h80, a); i2c_stop; tk(8);
    i2c_start; wbyte(8'h98, a); chk("R2 old address rejected after reload", a, 0); i2c_stop; tk(8);
    i2c_start; wbyte(8'hD8, a); chk("R2 new address after reload", a, 1);
    wbyte(8'h12, a); wbyte(8'h5A, a); i2c_stop; tk(8);
    chk("R2 write via new address", rg(18), 8'h5A);
    i2c_start; wbyte(8'hD8, a); wbyte(8'h24, a);
    i2c_start; wbyte(8'hD9, a); rbyte(d, 0); i2c_stop; tk(8);
    chk("R2 command register reads zero", d, 8'h00);
    strap = 0;
    i2c_start; wbyte(8'hD8, a); wbyte(8'h24, a); wbyte(8'h40, a); i2c_stop; tk(8);
    chk("R2 soft reset clears reg 0x10", rg(16), 8'h00);
    chk("R2 soft reset clears reg 0x12", rg(18), 8'h00);
    i2c_start; wbyte(8'h98, a); chk("R2 address back to low strap", a, 1); i2c_stop; tk(8);
  endtask

  task automatic t_reset_strap;
    logic a;
    strap = 1; rst_n = 0; tk(4); rst_n = 1; tk(4);
    strap = 0; tk(4);
    i2c_start; wbyte(8'hD8, a); chk("R1 high strap gives 0x6C", a, 1); i2c_stop; tk(8);
    i2c_start; wbyte(8'h98, a); chk("R1 strap change after reset ignored", a, 0); i2c_stop; tk(8);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end

  initial begin
    tk(5); rst_n = 1; tk(5);
    t_reset;
    t_write_read;
    t_wrap;
    t_bad_addr;
    t_rs_abort;
    t_sample;
    t_sample_ro;
    t_strap;
    t_reset_strap;
    chk("R9 sda_oe stable while SCL high", r9_bad, 0);
    $display("[TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end
endmodule